// File: doc/BRIEF.md
# Square-Wave Tone Channel with Length, Envelope and Frequency Sweep

This block is one tone voice of a sound subsystem. It produces a 4-bit digital amplitude on every system clock: a square wave whose high fraction is chosen from four duty settings and whose level is the present envelope volume. A programmable 11-bit pitch sets how long each of the eight duty steps lasts. Three slow processes act on the tone: a length counter that can silence the voice after a set time, a volume envelope that ramps the level up or down, and a frequency sweep that repeatedly shifts the pitch and can cut the voice off when the pitch leaves its range. All three restart when the trigger bit is written.

Software configures the voice through five byte-wide registers selected by `reg_sel`: 0 sweep, 1 shape (duty and length), 2 envelope, 3 pitch low byte, 4 pitch high bits and control. The slow timing ticks come from an internal frame sequencer that divides the system clock by `TICK_DIV` per step and walks through eight steps. Mixing, conversion to analog, panning and master volume belong to other blocks.

The voice is a two-state machine. States: `CH_IDLE` (silent, output 0) and `CH_PLAY` (tone present). Transitions: START (`CH_IDLE` to `CH_PLAY` on a trigger whose immediate sweep check passes), RESTART (`CH_PLAY` to `CH_PLAY` on a passing trigger), LEN_STOP (`CH_PLAY` to `CH_IDLE` when an enabled length counter runs out), SWEEP_CUT (`CH_PLAY` to `CH_IDLE` when a sweep result exceeds 2047, or any trigger whose immediate check fails).

Top module: `sqch_tone_channel`

## Requirements
- R1: After reset `amp_out` is 0 and `chan_active` is 0; register writes without bit 7 set in the pitch-high register (select 4) never start the voice.
- R2: Bits 7-6 of the shape register (select 1) pick the duty: codes 0, 1, 2, 3 give 1, 2, 4 and 6 high steps out of every 8.
- R3: Each duty step lasts (2048 - f) * 4 system clocks, where f is pitch-high bits 2-0 above the 8-bit pitch-low register (select 3).
- R4: On a trigger the volume is loaded from envelope-register (select 2) bits 7-4; while playing, `amp_out` equals the volume during high steps and 0 during low steps.
- R5: With a nonzero envelope period p (bits 2-0), the volume moves by one every p envelope ticks, upward when bit 3 is 1 and downward when it is 0, holding at 15 and at 0.
- R6: An envelope period of 0 leaves the volume unchanged.
- R7: Writing the shape register loads the length counter with 64 minus bits 5-0; each length tick lowers it; when pitch-high bit 6 is 1 and it reaches zero the voice stops, and when bit 6 is 0 the counter never stops the voice.
- R8: A trigger restarts the voice, reloads an exhausted length counter with 64, restarts the envelope and the sweep, and resets the duty step.
- R9: On a trigger with a nonzero sweep shift (sweep bits 2-0) and adding direction, f + (f >> shift) above 2047 leaves the voice idle.
- R10: On each expiry of the sweep timer (sweep bits 6-4 nonzero, in sweep ticks), the next pitch f ± (f >> shift) above 2047 stops the voice; otherwise it replaces the pitch.
- R11: Subtracting sweeps (sweep bit 3 = 1) never stop the voice.
- R12: A sweep time of 0 performs no recalculation on sweep ticks.
- R13: The frame sequencer advances one of 8 steps every `TICK_DIV` clocks; length ticks occur on even steps, sweep ticks on steps 2 and 6, envelope ticks on step 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 sweep, 1 shape, 2 envelope, 3 pitch low, 4 pitch high/control) |
| reg_wdata | input | 8 | Write data byte |
| amp_out | output | 4 | Digital output amplitude |
| chan_active | output | 1 | High while the voice is in the playing state |

## Verification
On every cycle the assertions check that a passing trigger enters the playing state, that an expiring length counter stops it, that the duty step only moves on a timer expiry, that the envelope holds when its period is zero and saturates at the top, and that subtracting or untimed sweeps never write or cut the voice. Duty fractions, step duration in clocks, the length and sweep lifetimes in real tick counts and the saturation level reached over many ticks depend on long stretches of time and on register sequences, so only the bench's directed scenarios show them.

// File: rtl/sqch_pkg.sv
package sqch_pkg;

    // Register select codes; the pitch-high register carries the trigger.
    typedef enum logic [2:0] {
        SEL_SWEEP = 3'd0,
        SEL_SHAPE = 3'd1,
        SEL_ENV   = 3'd2,
        SEL_FLO   = 3'd3,
        SEL_FHI   = 3'd4
    } reg_sel_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PLAY = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic [3:0] init;
        logic       up;
        logic [2:0] period;
    } env_cfg_t;

    typedef struct packed {
        logic [2:0] pace;
        logic       sub;
        logic [2:0] shift;
    } swp_cfg_t;

    // High/low level of each of the eight duty steps per code.
    function automatic logic duty_level(input logic [1:0] code, input logic [2:0] pos);
        logic lvl;
        unique case (code)
            2'd0:    lvl = (pos == 3'd7);
            2'd1:    lvl = (pos == 3'd0) || (pos == 3'd7);
            2'd2:    lvl = (pos == 3'd0) || (pos >= 3'd5);
            default: lvl = (pos != 3'd0) && (pos != 3'd7);
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/sqch_frame_seq.sv
module sqch_frame_seq #(
    parameter int TICK_DIV = 8192
) (
    input  logic clk,
    input  logic rst_n,
    output logic len_tick,
    output logic swp_tick,
    output logic env_tick
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [2:0]       step_q;
    logic             wrap;

    assign wrap = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            step_q <= '0;
        end else if (wrap) begin
            pre_q  <= '0;
            step_q <= step_q + 3'd1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    always_comb begin
        len_tick = wrap && !step_q[0];
        swp_tick = wrap && (step_q == 3'd2 || step_q == 3'd6);
        env_tick = wrap && (step_q == 3'd7);
    end

    // R13: envelope ticks sit on an odd step, never on a length step
    a_r13_env_not_len: assert property (@(posedge clk) disable iff (!rst_n)
        env_tick |-> !len_tick) else $error("R13 envelope tick coincided with length tick");

    // R13: consecutive length ticks are at least one step apart
    a_r13_len_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        len_tick |=> !len_tick) else $error("R13 back-to-back length ticks");

endmodule

// File: rtl/sqch_envelope.sv
module sqch_envelope
    import sqch_pkg::*;
#(
    parameter int VOL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             env_tick,
    input  env_cfg_t         cfg,
    output logic [VOL_W-1:0] vol
);
    localparam logic [VOL_W-1:0] VOL_MAX = {VOL_W{1'b1}};

    logic [2:0]       tmr_q;
    logic [VOL_W-1:0] vol_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q <= '0;
            tmr_q <= '0;
        end else if (trig) begin
            vol_q <= VOL_W'(cfg.init);
            tmr_q <= cfg.period;
        end else if (env_tick && cfg.period != 3'd0) begin
            if (tmr_q <= 3'd1) begin
                tmr_q <= cfg.period;
                if (cfg.up && vol_q != VOL_MAX)
                    vol_q <= vol_q + 1'b1;
                else if (!cfg.up && vol_q != '0)
                    vol_q <= vol_q - 1'b1;
            end else begin
                tmr_q <= tmr_q - 3'd1;
            end
        end
    end

    assign vol = vol_q;

    // R4: trigger loads the initial volume
    a_r4_trig_load: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> vol_q == VOL_W'($past(cfg.init))) else $error("R4 volume not loaded on trigger");

    // R5: rising envelope holds at the top
    a_r5_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && cfg.up && vol_q == VOL_MAX) |=> vol_q == VOL_MAX) else $error("R5 volume wrapped above maximum");

    // R5: falling envelope holds at zero
    a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !cfg.up && vol_q == '0) |=> vol_q == '0) else $error("R5 volume wrapped below zero");

    // R6: zero period freezes the volume
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && cfg.period == 3'd0) |=> $stable(vol_q)) else $error("R6 volume moved with zero period");

endmodule

// File: rtl/sqch_sweep.sv
module sqch_sweep
    import sqch_pkg::*;
#(
    parameter int FREQ_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              swp_tick,
    input  swp_cfg_t          cfg,
    input  logic [FREQ_W-1:0] freq_in,
    output logic              wr,
    output logic [FREQ_W-1:0] wr_freq,
    output logic              kill
);
    localparam int SUM_W = FREQ_W + 1;

    logic [FREQ_W-1:0] shadow_q;
    logic [2:0]        tmr_q;
    logic              armed_q;
    logic [SUM_W-1:0]  next_tick;
    logic [SUM_W-1:0]  next_trig;
    logic              fire;

    function automatic logic [SUM_W-1:0] step_calc(input logic [FREQ_W-1:0] f,
                                                   input logic sub,
                                                   input logic [2:0] sh);
        logic [SUM_W-1:0] base;
        logic [SUM_W-1:0] delta;
        base  = {1'b0, f};
        delta = base >> sh;
        return sub ? (base - delta) : (base + delta);
    endfunction

    always_comb begin
        next_tick = step_calc(shadow_q, cfg.sub, cfg.shift);
        next_trig = step_calc(freq_in, cfg.sub, cfg.shift);
        fire      = swp_tick && !trig && (tmr_q <= 3'd1) && armed_q && (cfg.pace != 3'd0);
        wr        = fire && !next_tick[FREQ_W] && (cfg.shift != 3'd0);
        wr_freq   = next_tick[FREQ_W-1:0];
        kill      = (trig && cfg.shift != 3'd0 && next_trig[FREQ_W])
                  || (fire && next_tick[FREQ_W]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            tmr_q    <= '0;
            armed_q  <= 1'b0;
        end else if (trig) begin
            shadow_q <= freq_in;
            tmr_q    <= cfg.pace;
            armed_q  <= (cfg.pace != 3'd0) || (cfg.shift != 3'd0);
        end else if (swp_tick) begin
            if (tmr_q <= 3'd1) begin
                tmr_q <= cfg.pace;
                if (wr)
                    shadow_q <= wr_freq;
            end else begin
                tmr_q <= tmr_q - 3'd1;
            end
        end
    end

    // R11: a subtracting sweep never cuts the voice on a tick
    a_r11_sub_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sub && !trig) |-> !kill) else $error("R11 subtracting sweep cut the voice");

    // R12: untimed sweep neither writes nor cuts
    a_r12_pace_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.pace == 3'd0 && !trig) |-> (!wr && !kill)) else $error("R12 sweep acted with time 0");

endmodule

// File: rtl/sqch_tone_channel.sv
module sqch_tone_channel
    import sqch_pkg::*;
#(
    parameter int TICK_DIV   = 8192,
    parameter int FREQ_W     = 11,
    parameter int VOL_W      = 4,
    parameter int LEN_W      = 6,
    parameter int MULT_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [VOL_W-1:0] amp_out,
    output logic             chan_active
);
    localparam int TMR_W  = FREQ_W + MULT_SHIFT;
    localparam int SPAN_W = TMR_W + 1;
    localparam int CNT_W  = LEN_W + 1;
    localparam int HI_W   = FREQ_W - 8;
    localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(1 << LEN_W);

    // ---------------- configuration registers ----------------
    swp_cfg_t          swp_cfg_q;
    env_cfg_t          env_cfg_q;
    logic [1:0]        duty_q;
    logic              len_en_q;
    logic [FREQ_W-1:0] freq_q;

    logic              trig;
    logic [FREQ_W-1:0] trig_freq;
    logic [FREQ_W-1:0] sweep_src;

    logic len_tick, swp_tick, env_tick;
    logic swp_wr, swp_kill;
    logic [FREQ_W-1:0] swp_freq;
    logic [VOL_W-1:0]  vol;

    assign trig      = reg_wr && (reg_sel == SEL_FHI) && reg_wdata[7];
    assign trig_freq = {reg_wdata[HI_W-1:0], freq_q[7:0]};
    assign sweep_src = trig ? trig_freq : freq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swp_cfg_q <= '0;
            env_cfg_q <= '0;
            duty_q    <= '0;
            len_en_q  <= 1'b0;
            freq_q    <= '0;
        end else begin
            if (swp_wr)
                freq_q <= swp_freq;
            if (reg_wr) begin
                unique case (reg_sel)
                    SEL_SWEEP: swp_cfg_q <= swp_cfg_t'(reg_wdata[6:0]);
                    SEL_SHAPE: duty_q    <= reg_wdata[7:6];
                    SEL_ENV:   env_cfg_q <= env_cfg_t'(reg_wdata);
                    SEL_FLO:   freq_q[7:0] <= reg_wdata;
                    SEL_FHI: begin
                        freq_q[FREQ_W-1:8] <= reg_wdata[HI_W-1:0];
                        len_en_q           <= reg_wdata[6];
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- sub-units ----------------
    sqch_frame_seq #(.TICK_DIV(TICK_DIV)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_tick (len_tick),
        .swp_tick (swp_tick),
        .env_tick (env_tick)
    );

    sqch_envelope #(.VOL_W(VOL_W)) u_env (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .env_tick (env_tick),
        .cfg      (env_cfg_q),
        .vol      (vol)
    );

    sqch_sweep #(.FREQ_W(FREQ_W)) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .swp_tick (swp_tick),
        .cfg      (swp_cfg_q),
        .freq_in  (sweep_src),
        .wr       (swp_wr),
        .wr_freq  (swp_freq),
        .kill     (swp_kill)
    );

    // ---------------- length counter ----------------
    logic [CNT_W-1:0] len_cnt_q;
    logic             len_expire;

    assign len_expire = len_tick && !trig && len_en_q && (len_cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_cnt_q <= '0;
        end else if (reg_wr && reg_sel == SEL_SHAPE) begin
            len_cnt_q <= LEN_FULL - CNT_W'(reg_wdata[LEN_W-1:0]);
        end else if (trig) begin
            if (len_cnt_q == '0)
                len_cnt_q <= LEN_FULL;
        end else if (len_tick && len_en_q && len_cnt_q != '0) begin
            len_cnt_q <= len_cnt_q - 1'b1;
        end
    end

    // ---------------- pitch timer and duty step ----------------
    logic [TMR_W-1:0] tmr_q;
    logic [2:0]       pos_q;

    function automatic logic [TMR_W-1:0] reload_of(input logic [FREQ_W-1:0] f);
        logic [SPAN_W-1:0] span;
        span = (SPAN_W'(1 << FREQ_W) - SPAN_W'(f)) << MULT_SHIFT;
        return TMR_W'(span - SPAN_W'(1));
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
            pos_q <= '0;
        end else if (trig) begin
            tmr_q <= reload_of(trig_freq);
            pos_q <= '0;
        end else if (tmr_q == '0) begin
            tmr_q <= reload_of(freq_q);
            pos_q <= pos_q + 3'd1;
        end else begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    // ---------------- voice state machine ----------------
    ch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= CH_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (trig && !swp_kill)
                    state_d = CH_PLAY;          // START
            end
            CH_PLAY: begin
                if (trig)
                    state_d = swp_kill ? CH_IDLE : CH_PLAY;  // SWEEP_CUT / RESTART
                else if (len_expire)
                    state_d = CH_IDLE;          // LEN_STOP
                else if (swp_kill)
                    state_d = CH_IDLE;          // SWEEP_CUT
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        chan_active = (state_q == CH_PLAY);
        amp_out     = (chan_active && duty_level(duty_q, pos_q)) ? vol : '0;
    end

    // R8: a passing trigger always leads to the playing state
    a_r8_trig_start: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !swp_kill) |=> chan_active) else $error("R8 trigger did not start voice");

    // R7: an enabled length counter running out stops the voice
    a_r7_len_stop: assert property (@(posedge clk) disable iff (!rst_n)
        len_expire |=> !chan_active) else $error("R7 length expiry left voice playing");

    // R3: the duty step holds while the pitch timer is counting
    a_r3_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && tmr_q != '0) |=> pos_q == $past(pos_q)) else $error("R3 duty step moved early");

    // R10: a sweep write-back becomes the pitch unless software writes it
    a_r10_freq_take: assert property (@(posedge clk) disable iff (!rst_n)
        (swp_wr && !(reg_wr && (reg_sel == SEL_FLO || reg_sel == SEL_FHI)))
        |=> freq_q == $past(swp_freq)) else $error("R10 sweep result not written back");

endmodule

// File: tb/sqch_tone_channel_tb.sv
module sqch_tone_channel_tb_top;

    localparam int TDIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [3:0] amp_out;
    logic       chan_active;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;   // 125 MHz

    sqch_tone_channel #(.TICK_DIV(TDIV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .amp_out     (amp_out),
        .chan_active (chan_active)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_fails  = n_fails + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sample n cycles: cycles with nonzero amplitude and the peak value
    task automatic observe(input int n, output int high, output int peak);
        high = 0; peak = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (amp_out != 0) high++;
            if (int'(amp_out) > peak) peak = int'(amp_out);
        end
    endtask

    // program pitch (no trigger) then trigger with length enable bit
    task automatic start(input int f, input logic len_en);
        wr(3'd3, 8'(f & 8'hFF));
        wr(3'd4, {1'b1, len_en, 3'b000, 3'((f >> 8) & 7)});
    endtask

    task automatic t_reset();
        check("R1 reset amplitude", int'(amp_out), 0);
        check("R1 reset active", int'(chan_active), 0);
        wr(3'd2, 8'hF0);
        wr(3'd3, 8'hFE);
        wr(3'd4, 8'h47);            // bit7 clear: no trigger
        idle(40);
        check("R1 no start without trigger", int'(chan_active), 0);
        check("R1 silent without trigger", int'(amp_out), 0);
    endtask

    task automatic t_duty();
        int hc[4] = '{1, 2, 4, 6};
        int high, peak;
        for (int c = 0; c < 4; c++) begin
            wr(3'd0, 8'h00);
            wr(3'd1, {2'(c), 6'd0});
            wr(3'd2, 8'hA0);       // volume 10, period 0
            start(2046, 1'b0);     // 8 clocks per step, 64 per cycle
            idle(20);
            observe(64, high, peak);
            check($sformatf("R2 duty code %0d high cycles", c), high, hc[c] * 8);
            check($sformatf("R4 duty code %0d level", c), peak, 10);
        end
    endtask

    task automatic t_period(input int f);
        int run;
        int guard;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);           // 12.5%: one high step per cycle
        wr(3'd2, 8'hF0);
        start(f, 1'b0);
        guard = 0;
        @(negedge clk);
        while (amp_out != 0 && guard < 20000) begin @(negedge clk); guard++; end
        while (amp_out == 0 && guard < 20000) begin @(negedge clk); guard++; end
        run = 0;
        while (amp_out != 0 && guard < 20000) begin @(negedge clk); run++; guard++; end
        check($sformatf("R3 step length f=%0d", f), run, (2048 - f) * 4);
    endtask

    task automatic t_envelope();
        int high, peak;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h80);
        wr(3'd2, 8'hD9);           // init 13, up, period 1
        start(2046, 1'b0);
        idle(300);
        observe(64, high, peak);
        check("R5 rising envelope holds at 15", peak, 15);

        wr(3'd2, 8'h21);           // init 2, down, period 1
        start(2046, 1'b0);
        idle(300);
        observe(64, high, peak);
        check("R5 falling envelope holds at 0", peak, 0);
        check("R5 voice still playing at volume 0", int'(chan_active), 1);

        wr(3'd2, 8'h98);           // init 9, up, period 0
        start(2046, 1'b0);
        idle(500);
        observe(64, high, peak);
        check("R6 zero period keeps volume", peak, 9);
    endtask

    task automatic t_length();
        int high, peak;
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hF0);
        wr(3'd1, {2'b10, 6'd60});  // counter 4, length tick every 16 clocks
        start(2046, 1'b1);
        idle(30);
        check("R7 R13 still playing before 4 length ticks", int'(chan_active), 1);
        idle(100);
        check("R7 R13 stopped after 4 length ticks", int'(chan_active), 0);
        observe(64, high, peak);
        check("R7 silent after length stop", peak, 0);

        start(2046, 1'b1);         // exhausted counter reloads to 64
        idle(200);
        check("R8 retrigger restarts with full length", int'(chan_active), 1);

        wr(3'd1, {2'b10, 6'd60});
        start(2046, 1'b0);         // length disabled
        idle(300);
        check("R7 disabled length never stops", int'(chan_active), 1);
    endtask

    task automatic t_sweep();
        wr(3'd1, 8'h80);
        wr(3'd2, 8'hF0);
        wr(3'd0, 8'h11);           // time 1, add, shift 1
        start(1500, 1'b0);         // 1500 + 750 > 2047
        idle(10);
        check("R9 trigger overflow keeps voice idle", int'(chan_active), 0);

        start(1024, 1'b0);         // 1536 fits, next 2304 does not
        idle(5);
        check("R9 trigger check passes", int'(chan_active), 1);
        idle(200);
        check("R10 write-back leads to overflow stop", int'(chan_active), 0);

        wr(3'd0, 8'h19);           // time 1, subtract, shift 1
        start(2046, 1'b0);
        idle(300);
        check("R11 subtracting sweep keeps playing", int'(chan_active), 1);

        wr(3'd0, 8'h01);           // time 0, add, shift 1
        start(1024, 1'b0);
        idle(300);
        check("R12 untimed sweep keeps pitch", int'(chan_active), 1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        t_reset();
        t_duty();
        t_period(2040);
        t_period(2000);
        t_envelope();
        t_length();
        t_sweep();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule